// File: doc/BRIEF.md
# Descriptor Writeback Coalescing Controller

This block returns consumed descriptors from a local cache to a circular ring in host memory, and it owns the hardware head index of that ring. A caller raises a writeback request with an alignment mask. It also supplies the current count of used descriptors, the ring length, the ring base address and a programmable issue delay. The controller works out how many descriptors to write in one burst. It clips the burst at the end of the ring, or it rounds the count down to a multiple set by the mask. After the delay it raises a DMA write request. On completion it releases the written entries from the used queue and advances the head modulo the ring length.

Only one writeback is in flight at a time. A request that arrives while a burst is busy is not started. If its mask is numerically smaller (less restrictive) than the stored one, the controller keeps the new mask and marks a follow-up. A burst cut short by the ring end marks a follow-up too. One cycle after completion, a marked follow-up is evaluated again with the stored mask, against the updated head and used count. While the drain input is high at delay expiry, the delay is re-armed and no DMA is issued.

The used queue sits outside this block. It must remove `used_pop_cnt_o` entries at the clock edge where `used_pop_o` is high, so that `used_cnt_i` is already updated in the next cycle.

Top module: `desc_wb_coalescer`

## Requirements
- R1: After synchronous reset, `head_o` is 0 and `dma_req_o`, `head_upd_o`, `used_pop_o` and `busy_o` are 0.
- R2: An idle request where used+head is below the ring length gives a burst of `used & ~mask`; a zero mask gives the whole used count.
- R3: An idle request where used+head is at least the ring length gives a burst of length−head, with no alignment applied, and a follow-up is marked.
- R4: A request whose burst count works out to zero starts nothing: `dma_req_o` stays low, `busy_o` stays low and the head is unchanged.
- R5: `dma_req_o` rises exactly delay+1 cycles after the clock edge that accepts an idle request. While `drain_i` is high at expiry, the delay is reloaded and no request is issued.
- R6: While `dma_req_o` is high, `dma_addr_o` is base + head×16 and `dma_len_o` is count×16 (16-byte descriptors). Both are held stable until `dma_done_i`.
- R7: `dma_done_i` during an active request pulses `used_pop_o` with `used_pop_cnt_o` = count in that same cycle. At the next edge the head becomes (head+count) mod length, with a one-cycle `head_upd_o` strobe, and the head changes at no other time.
- R8: A request during a busy writeback with a mask numerically smaller than the stored mask marks a follow-up using the new mask. An equal or larger mask is dropped without effect.
- R9: A marked follow-up is evaluated with the stored mask one cycle after completion, and it starts its delay from there, so `dma_req_o` rises delay+2 cycles after the completion edge.
- R10: `dma_done_i` with no active DMA request is ignored: no pop, no head change, no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_req_i | input | 1 | Writeback request pulse |
| wb_mask_i | input | IDX_W | Alignment mask carried with the request |
| used_cnt_i | input | IDX_W | Used descriptors currently in the cache |
| ring_len_i | input | IDX_W | Ring length in descriptors (nonzero) |
| ring_base_i | input | ADDR_W | Ring base byte address |
| delay_i | input | DLY_W | Cycles to wait before issuing the DMA write |
| drain_i | input | 1 | Hold off DMA issue; delay is re-armed |
| dma_req_o | output | 1 | DMA write request, held until done |
| dma_addr_o | output | ADDR_W | DMA write byte address |
| dma_len_o | output | LEN_W | DMA write byte length |
| dma_done_i | input | 1 | DMA write completion pulse |
| used_pop_o | output | 1 | Remove entries from the used queue |
| used_pop_cnt_o | output | IDX_W | Number of entries to remove |
| head_o | output | IDX_W | Hardware head index |
| head_upd_o | output | 1 | One-cycle strobe with a new head value |
| busy_o | output | 1 | A writeback is in progress |

## Verification
The embedded properties watch on every cycle that the head moves only together with its strobe and that the strobe never lasts two cycles. They also check that a burst never runs past the ring end, that the DMA address and length hold steady for the whole request, and that no request rises out of a drain cycle. The alignment arithmetic, coalescing by mask order, dropping of more restrictive requests, follow-up replay after a ring-end split and the exact issue latency depend on multi-step sequences. Only the bench scenarios show these, by comparing burst lengths, addresses and head values against an independent model.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    parameter int IDX_W      = 8;
    parameter int ADDR_W     = 32;
    parameter int DLY_W      = 8;
    parameter int DESC_BYTES = 16;

    localparam int DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int LEN_W      = IDX_W + DESC_SHIFT;
    localparam int PAD_W      = ADDR_W - LEN_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  blen_t;
    typedef logic [DLY_W-1:0]  dly_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ISSUE  = 2'd2,
        ST_REPLAY = 2'd3
    } wb_state_e;

    typedef struct packed {
        idx_t cnt;
        logic wrap;
    } burst_plan_t;

    // Size one burst: clip at the ring end, otherwise round down by the mask.
    function automatic burst_plan_t plan_burst(idx_t used, idx_t head, idx_t len, idx_t mask);
        burst_plan_t     p;
        logic [IDX_W:0]  reach;
        reach = {1'b0, used} + {1'b0, head};
        if (reach >= {1'b0, len}) begin
            p.cnt  = len - head;
            p.wrap = 1'b1;
        end else begin
            p.wrap = 1'b0;
            p.cnt  = (mask != '0) ? (used & ~mask) : used;
        end
        return p;
    endfunction

    function automatic addr_t desc_addr(addr_t base, idx_t idx);
        return base + {{PAD_W{1'b0}}, idx, {DESC_SHIFT{1'b0}}};
    endfunction

    function automatic blen_t desc_bytes(idx_t cnt);
        return {cnt, {DESC_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/dwb_burst_calc.sv
module dwb_burst_calc
    import dwb_pkg::*;
(
    input  idx_t        used_i,
    input  idx_t        head_i,
    input  idx_t        len_i,
    input  idx_t        mask_i,
    output burst_plan_t plan_o
);
    always_comb begin
        plan_o = plan_burst(used_i, head_i, len_i, mask_i);
    end
endmodule

// File: rtl/dwb_delay_timer.sv
module dwb_delay_timer
    import dwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  dly_t load_val_i,
    input  logic run_i,
    input  logic hold_i,
    output logic expired_o
);
    dly_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i) begin
            if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            else if (hold_i)
                cnt_q <= load_val_i;   // drain: re-arm the full delay
        end
    end

    assign expired_o = run_i && (cnt_q == '0) && !hold_i;
endmodule

// File: rtl/dwb_head_ring.sv
module dwb_head_ring
    import dwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  idx_t step_i,
    input  idx_t len_i,
    output idx_t head_o,
    output logic upd_o
);
    logic [IDX_W:0] sum;
    logic [IDX_W:0] wrapped;
    idx_t           head_q;
    logic           upd_q;

    always_comb begin
        sum     = {1'b0, head_q} + {1'b0, step_i};
        wrapped = (sum >= {1'b0, len_i}) ? (sum - {1'b0, len_i}) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= adv_i;
            if (adv_i)
                head_q <= wrapped[IDX_W-1:0];
        end
    end

    assign head_o = head_q;
    assign upd_o  = upd_q;
endmodule

// File: rtl/desc_wb_coalescer.sv
module desc_wb_coalescer
    import dwb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wb_req_i,
    input  logic [IDX_W-1:0]      wb_mask_i,
    input  logic [IDX_W-1:0]      used_cnt_i,
    input  logic [IDX_W-1:0]      ring_len_i,
    input  logic [ADDR_W-1:0]     ring_base_i,
    input  logic [DLY_W-1:0]      delay_i,
    input  logic                  drain_i,
    output logic                  dma_req_o,
    output logic [ADDR_W-1:0]     dma_addr_o,
    output logic [LEN_W-1:0]      dma_len_o,
    input  logic                  dma_done_i,
    output logic                  used_pop_o,
    output logic [IDX_W-1:0]      used_pop_cnt_o,
    output logic [IDX_W-1:0]      head_o,
    output logic                  head_upd_o,
    output logic                  busy_o
);
    wb_state_e   state_q, state_n;
    idx_t        mask_q, mask_n;
    logic        more_q, more_n;
    idx_t        out_cnt_q, out_cnt_n;

    idx_t        head;
    idx_t        eval_mask;
    burst_plan_t plan;
    logic        in_flight;
    logic        looser_req;
    logic        complete;
    logic        go;
    logic        tmr_expired;

    assign in_flight  = (state_q != ST_IDLE);
    assign looser_req = wb_req_i && in_flight && (wb_mask_i < mask_q);
    assign complete   = (state_q == ST_ISSUE) && dma_done_i;
    assign eval_mask  = (state_q == ST_REPLAY) ? mask_q : wb_mask_i;

    dwb_burst_calc u_calc (
        .used_i (used_cnt_i),
        .head_i (head),
        .len_i  (ring_len_i),
        .mask_i (eval_mask),
        .plan_o (plan)
    );

    dwb_delay_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (go),
        .load_val_i (delay_i),
        .run_i      (state_q == ST_WAIT),
        .hold_i     (drain_i),
        .expired_o  (tmr_expired)
    );

    dwb_head_ring u_head (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (complete),
        .step_i (out_cnt_q),
        .len_i  (ring_len_i),
        .head_o (head),
        .upd_o  (head_upd_o)
    );

    always_comb begin
        state_n   = state_q;
        mask_n    = mask_q;
        more_n    = more_q;
        out_cnt_n = out_cnt_q;
        go        = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (wb_req_i) begin
                    mask_n = wb_mask_i;
                    more_n = plan.wrap;
                    if (plan.cnt != '0) begin
                        out_cnt_n = plan.cnt;
                        state_n   = ST_WAIT;
                        go        = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_expired)
                    state_n = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (dma_done_i) begin
                    out_cnt_n = '0;
                    state_n   = (more_q || looser_req) ? ST_REPLAY : ST_IDLE;
                end
            end
            ST_REPLAY: begin
                more_n = plan.wrap;
                if (plan.cnt != '0) begin
                    out_cnt_n = plan.cnt;
                    state_n   = ST_WAIT;
                    go        = 1'b1;
                end else if (!looser_req) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        // Coalesce a less restrictive request into the running writeback.
        if (looser_req) begin
            mask_n = wb_mask_i;
            more_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mask_q    <= '0;
            more_q    <= 1'b0;
            out_cnt_q <= '0;
        end else begin
            state_q   <= state_n;
            mask_q    <= mask_n;
            more_q    <= more_n;
            out_cnt_q <= out_cnt_n;
        end
    end

    assign dma_req_o      = (state_q == ST_ISSUE);
    assign dma_addr_o     = desc_addr(ring_base_i, head);
    assign dma_len_o      = desc_bytes(out_cnt_q);
    assign used_pop_o     = complete;
    assign used_pop_cnt_o = out_cnt_q;
    assign head_o         = head;
    assign busy_o         = in_flight;

    a_r7_head_moves_with_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(head_o) |-> head_upd_o);

    a_r7_strobe_single_cycle: assert property (@(posedge clk) disable iff (rst)
        head_upd_o |=> !head_upd_o);

    a_r6_dma_fields_hold: assert property (@(posedge clk) disable iff (rst)
        (dma_req_o && !dma_done_i) |=> (dma_req_o && $stable(dma_addr_o) && $stable(dma_len_o)));

    a_r5_no_issue_from_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req_o) |-> $past(!drain_i));

    a_r3_burst_inside_ring: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> (({1'b0, head_o} + {1'b0, used_pop_cnt_o}) <= {1'b0, ring_len_i}));

    a_r10_pop_needs_request: assert property (@(posedge clk) disable iff (rst)
        used_pop_o |-> (dma_req_o && !head_upd_o));
endmodule

// File: tb/desc_wb_coalescer_tb_top.sv
module desc_wb_coalescer_tb_top;
    import dwb_pkg::*;

    localparam int    LEN  = 12;
    localparam addr_t BASE = 32'h0000_4000;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  wb_req = 1'b0;
    idx_t  wb_mask = '0;
    idx_t  used = '0;
    dly_t  dly = '0;
    logic  drain = 1'b0;
    logic  dma_done = 1'b0;
    logic  dma_req;
    addr_t dma_addr;
    blen_t dma_len;
    logic  used_pop;
    idx_t  used_pop_cnt;
    idx_t  head;
    logic  head_upd;
    logic  busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int head_m = 0;
    int used_v = 0;

    always #5 clk = ~clk;

    desc_wb_coalescer dut_i (
        .clk            (clk),
        .rst            (rst),
        .wb_req_i       (wb_req),
        .wb_mask_i      (wb_mask),
        .used_cnt_i     (used),
        .ring_len_i     (idx_t'(LEN)),
        .ring_base_i    (BASE),
        .delay_i        (dly),
        .drain_i        (drain),
        .dma_req_o      (dma_req),
        .dma_addr_o     (dma_addr),
        .dma_len_o      (dma_len),
        .dma_done_i     (dma_done),
        .used_pop_o     (used_pop),
        .used_pop_cnt_o (used_pop_cnt),
        .head_o         (head),
        .head_upd_o     (head_upd),
        .busy_o         (busy)
    );

    // used, mask, delay, expected first burst count
    localparam logic [31:0] VEC [6] = '{
        {8'd5, 8'd0, 8'd0, 8'd5},   // R2 zero mask
        {8'd6, 8'd3, 8'd3, 8'd4},   // R2 rounded down
        {8'd2, 8'd3, 8'd1, 8'd0},   // R4 rounds to zero
        {8'd6, 8'd1, 8'd2, 8'd3},   // R3 split at ring end, replay
        {8'd9, 8'd7, 8'd4, 8'd8},   // R2 coarse mask
        {8'd2, 8'd0, 8'd1, 8'd2}    // R3 exact fit, replay finds none
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_cnt(int u, int h, int m, output bit more);
        if (u + h >= LEN) begin
            more = 1'b1;
            return LEN - h;
        end
        more = 1'b0;
        return (m != 0) ? (u & ~m) : u;
    endfunction

    // Complete one DMA burst of cnt descriptors and check the head update.
    task automatic finish_burst(input int cnt, input int new_used);
        dma_done = 1'b1;
        #1;
        chk(used_pop && used_pop_cnt == idx_t'(cnt), "R7 pop", used_pop_cnt, cnt);
        tick;
        dma_done = 1'b0;
        head_m = (head_m + cnt) % LEN;
        used_v = new_used;
        used   = idx_t'(used_v);
        chk(head == idx_t'(head_m) && head_upd, "R7 head", head, head_m);
    endtask

    task automatic wait_req(input int exp_lat, input string tag);
        int n = 0;
        while (!dma_req && n < 60) begin
            tick;
            n++;
        end
        chk(n == exp_lat, tag, n, exp_lat);
    endtask

    task automatic run_req(input int u, input int m, input int d, input int exp_first);
        bit first = 1'b1;
        bit more;
        int c;
        used_v  = u;
        used    = idx_t'(u);
        wb_mask = idx_t'(m);
        dly     = dly_t'(d);
        wb_req  = 1'b1;
        tick;
        wb_req  = 1'b0;
        for (int guard = 0; guard < 4; guard++) begin
            c = model_cnt(used_v, head_m, m, more);
            if (first)
                chk(c == exp_first, "R2 R3 table count", c, exp_first);
            if (c == 0) begin
                repeat (3) tick;
                chk(!dma_req && !busy && head == idx_t'(head_m), "R4 nothing started", dma_req, 0);
                break;
            end
            wait_req(first ? d + 1 : d + 2, first ? "R5 issue latency" : "R9 replay latency");
            chk(dma_addr == BASE + addr_t'(head_m * 16), "R6 address", dma_addr, BASE + head_m * 16);
            chk(dma_len == blen_t'(c * 16), more ? "R3 clipped length" : "R6 length", dma_len, c * 16);
            finish_burst(c, used_v - c);
            if (!more) begin
                tick;
                chk(!busy && !head_upd, "R7 idle after burst", busy, 0);
                break;
            end
            first = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        chk(head == '0 && !dma_req && !head_upd && !used_pop && !busy, "R1 reset state", head, 0);
        rst = 1'b0;
        tick;
        chk(head == '0 && !busy, "R1 after release", head, 0);

        for (int i = 0; i < 6; i++)
            run_req(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));

        // R8: looser request during a busy burst is coalesced and replayed (R9)
        used = 8'd9; used_v = 9; wb_mask = 8'd7; dly = 8'd6;
        wb_req = 1'b1; tick; wb_req = 1'b0;
        tick; tick;
        wb_mask = 8'd1; wb_req = 1'b1; tick; wb_req = 1'b0;
        wait_req(4, "R5 latency with coalesce");
        chk(dma_len == blen_t'(8 * 16), "R8 first burst unchanged", dma_len, 128);
        finish_burst(8, 3);
        wait_req(8, "R9 coalesced replay latency");
        chk(dma_len == blen_t'(2 * 16), "R8 replay uses looser mask", dma_len, 32);
        chk(dma_addr == BASE + addr_t'(8 * 16), "R9 replay address", dma_addr, BASE + 128);
        finish_burst(2, 1);
        tick;
        chk(!busy, "R9 idle after replay", busy, 0);

        // R8: tighter-or-equal request during a busy burst is dropped
        used = 8'd1; used_v = 1; wb_mask = 8'd0; dly = 8'd4;
        wb_req = 1'b1; tick; wb_req = 1'b0;
        tick;
        wb_mask = 8'd3; wb_req = 1'b1; tick; wb_req = 1'b0;
        wait_req(3, "R5 latency with dropped request");
        chk(dma_len == blen_t'(16), "R8 length unaffected", dma_len, 16);
        finish_burst(1, 5);
        repeat (6) begin
            tick;
            chk(!dma_req && !busy && head == idx_t'(11), "R8 no replay from dropped request", dma_req, 0);
        end

        // R5: drain holds off the issue and re-arms the delay
        drain = 1'b1;
        used = 8'd1; used_v = 1; wb_mask = 8'd0; dly = 8'd2;
        wb_req = 1'b1; tick; wb_req = 1'b0;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 10; k++) begin
                tick;
                if (dma_req) seen = 1'b1;
            end
            chk(!seen && busy, "R5 held during drain", seen, 0);
        end
        drain = 1'b0;
        begin
            int n = 0;
            while (!dma_req && n < 10) begin
                tick;
                n++;
            end
            chk(dma_req && n <= 3, "R5 issue after drain", n, 3);
        end
        chk(dma_addr == BASE + addr_t'(11 * 16) && dma_len == blen_t'(16), "R3 one left at ring end", dma_len, 16);
        finish_burst(1, 0);
        repeat (3) tick;
        chk(!busy && !dma_req && head == '0, "R3 replay with nothing used", head, 0);

        // R10: completion pulse with no DMA outstanding
        dma_done = 1'b1;
        #1;
        chk(!used_pop, "R10 no pop", used_pop, 0);
        tick;
        dma_done = 1'b0;
        chk(head == '0 && !head_upd && !busy, "R10 head unchanged", head, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule